// File: doc/BRIEF.md
# SPI Register-Access Slave

This block is the serial front end of a small device that holds sixteen 16-bit registers. While the chip select is low, an external master clocks in a command frame. The block decodes the frame into a read or write request, a 4-bit register address and 16 bits of data. A write reaches the register bank as a one-cycle strobe in the system clock domain, after the frame has ended. A read takes two frames. The first frame queues the request. During the next frame the block shifts the requested value back out, after an echo of the first frame's command header.

The serial logic runs from SCLK and from the chip-select edges. The write strobe crosses into the system clock domain through a toggle and a two-flop synchronizer. The block does not drive a pad directly. It provides the serial output value together with an output enable, and the enclosing pad builds the tri-state buffer from the two. A configuration input selects the SCLK edge on which the serial output advances.

Top module: `spi_regacc_slave`

## Requirements
- R1: SDI is sampled on SCLK falling edges while cs_n is low, most significant bit first. In the 24-bit frame, bit 23 is the command (0 = write, 1 = read), bits 22:20 are reserved, bits 19:16 are the register address and bits 15:0 are the data.
- R2: A frame that ends with fewer than 24 falling edges has no effect. It produces no wr_en pulse and does not change what the next frame shifts out.
- R3: When a frame has more than 24 falling edges, only the last 24 bits shifted in are decoded.
- R4: A valid write frame produces exactly one wr_en pulse. The pulse carries the frame's address on wr_addr and its data on wr_data, and arrives within 8 clk cycles after cs_n rises.
- R5: A valid read frame produces no wr_en. The address of the read is presented on rd_addr, and rd_data is captured when cs_n rises. The next frame shifts out the read frame's bits 23:16, followed by the captured data.
- R6: After a valid write frame, the next frame shifts out that write frame's bits 23:16, followed by 16 zero bits.
- R7: When cfg_sdo_rise is 0, sdo shows frame bit 23-k once k falling edges have occurred. When cfg_sdo_rise is 1, sdo advances only on the rising edges that follow the first falling edge of the frame, so each bit stays valid across the falling edge on which the master samples it.
- R8: While cs_n is high, sdo_oe and sdo are 0. SCLK and SDI activity in that time has no effect.
- R9: After rst, wr_en, wr_addr and wr_data are 0, and the first frame shifts out 24 zero bits.
- R10: wr_en is never high for two consecutive cycles. wr_addr and wr_data change only in a cycle in which wr_en is high.
- R11: After the 24th output bit of a frame, sdo stays 0 until cs_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high reset, synchronous in the clk domain |
| cs_n | input | 1 | Chip select, active low; its low period delimits a frame |
| sclk | input | 1 | Serial clock, free-running or gated |
| sdi | input | 1 | Serial data in, sampled on SCLK falling edges |
| sdo | output | 1 | Serial data out value |
| sdo_oe | output | 1 | Output enable for the SDO pad; 0 means high impedance |
| cfg_sdo_rise | input | 1 | 0: sdo advances on falling edges, 1: on rising edges |
| rd_addr | output | ADDR_W | Address of the register to read back |
| rd_data | input | DATA_W | Register bank read data for rd_addr |
| wr_en | output | 1 | One-cycle write strobe in the clk domain |
| wr_addr | output | ADDR_W | Write address, valid with wr_en |
| wr_data | output | DATA_W | Write data, valid with wr_en |

## Verification
The assertions take several things for granted about the inputs. clk is fast enough that a write toggle passes through the synchronizer well before the next frame can end. cs_n is held steady around each SCLK edge. cfg_sdo_rise changes only while cs_n is high. rd_data has settled on the value for rd_addr before cs_n rises. The stimulus respects all four. SCLK has a 60 ns period against the 5 ns system clock, the bench waits twelve clk cycles after every frame, and the chip select and the edge-select input move only between frames. The bench's register model is combinational, so rd_data follows rd_addr long before the frame ends.

// File: rtl/spi_regacc_pkg.sv
package spi_regacc_pkg;

  // command bit at the top of each frame
  typedef enum logic {
    CMD_WRITE = 1'b0,
    CMD_READ  = 1'b1
  } cmd_e;

  // which SCLK edge advances the serial output
  typedef enum logic {
    SDO_ON_FALL = 1'b0,
    SDO_ON_RISE = 1'b1
  } sdo_edge_e;

endpackage

// File: rtl/sra_rx_shift.sv
// Receive shifter in the SCLK domain. Rather than clearing the edge count
// asynchronously when chip select rises, it spots a new frame by comparing
// a token toggled at frame end with the token it last observed.
module sra_rx_shift #(
  parameter int unsigned FRAME_W = 24,
  parameter int unsigned CNT_W   = 5
) (
  input  logic               rst,
  input  logic               sclk,
  input  logic               cs_n,
  input  logic               sdi,
  input  logic               end_tog,
  output logic [FRAME_W-1:0] shreg,
  output logic [CNT_W-1:0]   falls
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

  logic [CNT_W-1:0] cnt;
  logic             seen_tog;
  logic             fresh;

  // the frame end has not yet been seen from this side: no edges in this frame
  assign fresh = end_tog ^ seen_tog;
  assign falls = fresh ? '0 : cnt;

  always_ff @(negedge sclk or posedge rst) begin
    if (rst) begin
      cnt      <= '0;
      seen_tog <= 1'b0;
    end else if (!cs_n) begin
      seen_tog <= end_tog;
      if (fresh)
        cnt <= CNT_W'(1);
      else if (cnt != FULL)
        cnt <= cnt + 1'b1;
    end
  end

  // pure data path, no reset needed: only a full frame is ever consumed
  always_ff @(negedge sclk) begin
    if (!cs_n)
      shreg <= {shreg[FRAME_W-2:0], sdi};
  end

endmodule

// File: rtl/sra_frame_commit.sv
// Frame end logic, clocked by the chip-select rising edge. It decides whether
// the frame is valid, loads the word for the next SDO frame and hands a write
// over to the system clock domain.
module sra_frame_commit
  import spi_regacc_pkg::*;
#(
  parameter int unsigned FRAME_W = 24,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned CNT_W   = 5
) (
  input  logic               rst,
  input  logic               cs_n,
  input  logic [FRAME_W-1:0] shreg,
  input  logic [CNT_W-1:0]   falls,
  input  logic [DATA_W-1:0]  rd_data,
  output logic [FRAME_W-1:0] tx_word,
  output logic               end_tog,
  output logic               wr_tog,
  output logic [ADDR_W-1:0]  hold_addr,
  output logic [DATA_W-1:0]  hold_data
);

  localparam int unsigned      HDR_W  = FRAME_W - DATA_W;
  localparam int unsigned      RW_BIT = FRAME_W - 1;
  localparam logic [CNT_W-1:0] FULL   = CNT_W'(FRAME_W);

  logic frame_ok;
  cmd_e cmd;

  assign frame_ok = (falls == FULL);
  assign cmd      = cmd_e'(shreg[RW_BIT]);

  always_ff @(posedge cs_n or posedge rst) begin
    if (rst) begin
      tx_word   <= '0;
      end_tog   <= 1'b0;
      wr_tog    <= 1'b0;
      hold_addr <= '0;
      hold_data <= '0;
    end else begin
      // a frame without any edge leaves the new-frame token as it is
      if (falls != '0)
        end_tog <= ~end_tog;
      if (frame_ok) begin
        tx_word <= {shreg[FRAME_W-1 -: HDR_W],
                    (cmd == CMD_READ) ? rd_data : {DATA_W{1'b0}}};
        if (cmd == CMD_WRITE) begin
          hold_addr <= shreg[DATA_W +: ADDR_W];
          hold_data <= shreg[DATA_W-1:0];
          wr_tog    <= ~wr_tog;
        end
      end
    end
  end

endmodule

// File: rtl/sra_sdo_drive.sv
// Serial output pointer and bit select. In falling-edge mode the pointer is
// the receive edge count. In rising-edge mode a separate counter advances on
// the rising edges that follow the first falling edge.
module sra_sdo_drive
  import spi_regacc_pkg::*;
#(
  parameter int unsigned FRAME_W = 24,
  parameter int unsigned CNT_W   = 5
) (
  input  logic               rst,
  input  logic               sclk,
  input  logic               cs_n,
  input  logic               cfg_sdo_rise,
  input  logic [CNT_W-1:0]   falls,
  input  logic [FRAME_W-1:0] tx_word,
  output logic               sdo,
  output logic               sdo_oe
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic             clr;
  logic [CNT_W-1:0] rcnt;
  logic [CNT_W-1:0] idx;
  logic [CNT_W-1:0] bitpos;
  sdo_edge_e        edge_sel;

  assign clr      = rst | cs_n;
  assign edge_sel = sdo_edge_e'(cfg_sdo_rise);

  always_ff @(posedge sclk or posedge clr) begin
    if (clr)
      rcnt <= '0;
    else if (falls != '0 && rcnt != FULL)
      rcnt <= rcnt + 1'b1;
  end

  assign idx    = (edge_sel == SDO_ON_RISE) ? rcnt : falls;
  assign bitpos = LAST - idx;

  always_comb begin
    sdo_oe = ~cs_n;
    sdo    = 1'b0;
    if (!cs_n && idx < FULL)
      sdo = tx_word[bitpos];
  end

endmodule

// File: rtl/sra_wr_sync.sv
// Brings the write toggle into the clk domain and turns each toggle into a
// one-cycle strobe with registered address and data.
module sra_wr_sync #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_tog,
  input  logic [ADDR_W-1:0] hold_addr,
  input  logic [DATA_W-1:0] hold_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  logic [SYNC_N-1:0] sync_q;
  logic              seen_q;
  logic              hit;

  assign hit = sync_q[SYNC_N-1] ^ seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= '0;
      seen_q  <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], wr_tog};
      seen_q <= sync_q[SYNC_N-1];
      wr_en  <= hit;
      if (hit) begin
        wr_addr <= hold_addr;
        wr_data <= hold_data;
      end
    end
  end

endmodule

// File: rtl/spi_regacc_slave.sv
module spi_regacc_slave #(
  parameter int unsigned FRAME_W = 24,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic              cfg_sdo_rise,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  localparam int unsigned CNT_W = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] shreg_w;
  logic [CNT_W-1:0]   falls_w;
  logic [FRAME_W-1:0] tx_word_w;
  logic               end_tog_w;
  logic               wr_tog_w;
  logic [ADDR_W-1:0]  hold_addr_w;
  logic [DATA_W-1:0]  hold_data_w;

  sra_rx_shift #(
    .FRAME_W(FRAME_W),
    .CNT_W  (CNT_W)
  ) u_rx (
    .rst    (rst),
    .sclk   (sclk),
    .cs_n   (cs_n),
    .sdi    (sdi),
    .end_tog(end_tog_w),
    .shreg  (shreg_w),
    .falls  (falls_w)
  );

  // address field of the most recent 24 bits feeds the register bank
  assign rd_addr = shreg_w[DATA_W +: ADDR_W];

  sra_frame_commit #(
    .FRAME_W(FRAME_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_commit (
    .rst      (rst),
    .cs_n     (cs_n),
    .shreg    (shreg_w),
    .falls    (falls_w),
    .rd_data  (rd_data),
    .tx_word  (tx_word_w),
    .end_tog  (end_tog_w),
    .wr_tog   (wr_tog_w),
    .hold_addr(hold_addr_w),
    .hold_data(hold_data_w)
  );

  sra_sdo_drive #(
    .FRAME_W(FRAME_W),
    .CNT_W  (CNT_W)
  ) u_sdo (
    .rst         (rst),
    .sclk        (sclk),
    .cs_n        (cs_n),
    .cfg_sdo_rise(cfg_sdo_rise),
    .falls       (falls_w),
    .tx_word     (tx_word_w),
    .sdo         (sdo),
    .sdo_oe      (sdo_oe)
  );

  sra_wr_sync #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .SYNC_N(SYNC_N)
  ) u_wsync (
    .clk      (clk),
    .rst      (rst),
    .wr_tog   (wr_tog_w),
    .hold_addr(hold_addr_w),
    .hold_data(hold_data_w),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

endmodule

// File: rtl/spi_regacc_slave_chk.sv
module spi_regacc_slave_chk #(
  parameter int unsigned FRAME_W = 24,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned CNT_W   = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              sdo_oe,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [CNT_W-1:0]  falls
);

  assert_wr_single_R10: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  assert_wr_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!$stable(wr_addr) || !$stable(wr_data)) |-> wr_en);

  assert_sdo_hiz_R8: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sdo_oe);

  assert_falls_cap_R3: assert property (@(posedge clk) disable iff (rst)
    falls <= CNT_W'(FRAME_W));

endmodule

bind spi_regacc_slave spi_regacc_slave_chk #(
  .FRAME_W(FRAME_W),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .cs_n   (cs_n),
  .sdo_oe (sdo_oe),
  .wr_en  (wr_en),
  .wr_addr(wr_addr),
  .wr_data(wr_data),
  .falls  (falls_w)
);

// File: tb/spi_regacc_slave_bench.sv
`timescale 1ns/1ps
module spi_regacc_slave_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic        sdi = 1'b0;
  logic        cfg_sdo_rise = 1'b0;
  logic        sdo, sdo_oe, wr_en;
  logic [3:0]  rd_addr, wr_addr;
  logic [15:0] rd_data, wr_data;

  int checks = 0;
  int fails  = 0;
  int wd     = 0;

  always #2.5 clk = ~clk;

  spi_regacc_slave u_spi_regacc_slave (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .cfg_sdo_rise(cfg_sdo_rise),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // register bank seen by the block, and the bench's own expectation of it
  logic [15:0] bank    [16];
  logic [15:0] exp_mem [16];
  assign rd_data = bank[rd_addr];

  function automatic logic [15:0] init_val(input int i);
    return 16'(i * 16'h1357) ^ 16'h5A3C;
  endfunction

  initial begin
    for (int i = 0; i < 16; i++) begin
      bank[i]    = init_val(i);
      exp_mem[i] = init_val(i);
    end
  end

  always @(posedge clk) if (wr_en) bank[wr_addr] <= wr_data;

  // write monitor, sampled away from the active edge
  int          pulses = 0;
  logic [3:0]  mon_addr;
  logic [15:0] mon_data;
  always @(negedge clk) begin
    if (wr_en) begin
      pulses   <= pulses + 1;
      mon_addr <= wr_addr;
      mon_data <= wr_data;
    end
  end

  // expected word of the next SDO frame and the requirement it stems from
  logic [23:0] exp_tx  = 24'h0;
  string       exp_tag = "R9";

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd == 200000) begin
      fails++;
      $display("FAIL R4 watchdog: cycles=%0d expected below %0d", wd, 200000);
      report();
      $finish;
    end
  end

  // one frame of nb bits, taken from fb[nb-1] down to fb[0]
  task automatic run_frame(input int nb, input logic [39:0] fb,
                           input logic rise_mode, input string ptag);
    logic [23:0] pre_w, post_w, exp_post, last24;
    int          extra_bad = 0;
    int          oe_bad = 0;
    int          exp_pulses;
    string       wtag, tag_used;
    logic [3:0]  waddr;
    logic [15:0] wdata;
    pre_w    = exp_tx;
    exp_post = rise_mode ? exp_tx : {exp_tx[22:0], 1'b0};
    post_w   = exp_post;
    tag_used = (ptag == "") ? exp_tag : ptag;
    pulses   = 0;
    cfg_sdo_rise = rise_mode;
    #10 cs_n = 1'b0;
    #10;
    for (int i = 0; i < nb; i++) begin
      sdi = fb[nb-1-i];
      #20 sclk = 1'b1;
      #10;
      if (i < 24) pre_w[23-i] = sdo;
      else if (sdo !== 1'b0) extra_bad++;
      if (sdo_oe !== 1'b1) oe_bad++;
      #10 sclk = 1'b0;
      #10;
      if (i < 24) post_w[23-i] = sdo;
      #10;
    end
    #20 cs_n = 1'b1;
    #10;
    check(tag_used, "sdo word before falling edges", 32'(pre_w), 32'(exp_tx));
    check("R7", "sdo word after falling edges", 32'(post_w), 32'(exp_post));
    check("R1", "sdo_oe low during frame", 32'(oe_bad), 32'd0);
    if (nb > 24) check("R11", "sdo bits past 24", 32'(extra_bad), 32'd0);
    check("R8", "sdo_oe after cs_n high", {31'd0, sdo_oe}, 32'd0);
    // model update
    exp_pulses = 0;
    waddr = 4'h0;
    wdata = 16'h0;
    if (nb < 24) wtag = "R2";
    else if (nb > 24) wtag = "R3";
    else if (fb[23]) wtag = "R5";
    else wtag = "R4";
    if (nb >= 24) begin
      last24 = fb[23:0];
      if (last24[23]) begin
        exp_tx  = {last24[23:16], exp_mem[last24[19:16]]};
        exp_tag = "R5";
      end else begin
        exp_tx  = {last24[23:16], 16'h0};
        exp_tag = "R6";
        exp_pulses = 1;
        waddr = last24[19:16];
        wdata = last24[15:0];
        exp_mem[waddr] = wdata;
      end
    end
    repeat (12) @(posedge clk);
    #1;
    check(wtag, "write pulse count", 32'(pulses), 32'(exp_pulses));
    if (exp_pulses == 1)
      check(wtag, "write addr and data", {12'd0, mon_addr, mon_data},
            {12'd0, waddr, wdata});
  endtask

  function automatic logic [39:0] mk(input logic rw, input logic [3:0] a,
                                     input logic [15:0] d);
    return {16'h0, rw, 3'b000, a, d};
  endfunction

  initial begin
    int unsigned seed = 32'h00C0FFEE;
    void'($urandom(seed));
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    // R9: reset state
    check("R9", "wr_en after reset", {31'd0, wr_en}, 32'd0);
    check("R9", "wr_addr and wr_data after reset", {12'd0, wr_addr, wr_data}, 32'd0);
    check("R8", "sdo_oe with cs_n high", {31'd0, sdo_oe}, 32'd0);

    // first frame after reset shifts zeros (R9); queue read of register 3
    run_frame(24, mk(1'b1, 4'h3, 16'hFFFF), 1'b0, "R9");
    // write register 5; read of register 3 comes back (R5), rising mode
    run_frame(24, mk(1'b0, 4'h5, 16'hA5C3), 1'b1, "R5");
    // read register 5; previous write header with zero data (R6)
    run_frame(24, mk(1'b1, 4'h5, 16'h0000), 1'b0, "R6");
    // short write frame must be dropped (R2)
    run_frame(12, mk(1'b0, 4'h5, 16'h0BAD), 1'b1, "R5");
    // SCLK and SDI activity while cs_n is high (R8)
    for (int i = 0; i < 16; i++) begin
      sdi = i[0];
      #15 sclk = 1'b1;
      #15 sclk = 1'b0;
      check("R8", "sdo_oe while cs_n high", {31'd0, sdo_oe}, 32'd0);
      check("R8", "sdo while cs_n high", {31'd0, sdo}, 32'd0);
    end
    // read-back of the written value proves field decode end to end (R1)
    run_frame(24, mk(1'b1, 4'h0, 16'h1234), 1'b0, "R1");
    // long frame, only the last 24 bits count (R3, R11)
    run_frame(32, {8'h0, 8'hE7, 1'b0, 3'b000, 4'h9, 16'h6B2D}, 1'b1, "");
    // frame with no clock edges at all (R2)
    run_frame(0, 40'h0, 1'b0, "");
    run_frame(24, mk(1'b1, 4'h9, 16'h0), 1'b0, "R2");
    run_frame(24, mk(1'b0, 4'hF, 16'h8001), 1'b1, "R5");

    // constrained random frames
    for (int n = 0; n < 50; n++) begin
      int          kind = $urandom_range(0, 9);
      int          nb;
      logic [39:0] fb;
      if (kind == 0) nb = $urandom_range(1, 23);
      else if (kind == 1) nb = $urandom_range(25, 40);
      else nb = 24;
      fb = {16'($urandom), 1'($urandom), 3'b000, 4'($urandom), 16'($urandom)};
      run_frame(nb, fb, 1'($urandom), "");
    end

    report();
    $finish;
  end

endmodule